// File: doc/BRIEF.md
# External Interrupt Controller

This block collects up to 32 asynchronous external interrupt lines and turns them into two requests toward the processor. Software picks a trigger kind for each line: level or edge, plus a polarity. Each line passes through a synchronizer. When a line meets its trigger condition, the block records a sticky pending bit. A pending bit on a line whose enable bit is set raises the general processor request. Line 0 can also drive a separate non-maskable request, which is gated only by its own control bit.

Software reaches the block through a plain synchronous register port with an address, a write strobe, write data and combinational read data. The enable bits have one write-only word that sets them, another that clears them, and a read-only view. Pending bits are cleared by writing ones to a dedicated word. Only `NUM_LINES` lines are built. The configuration bits of the missing lines read back as zero, so software can find the line count by writing all ones to the trigger-kind word and locating the highest bit that reads back set.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every readable word reads zero, and both `cpu_irq` and `nmi_irq` are low.
- R2: Writing to byte offset 0x00 sets the enable bits where the data has ones. Writing to 0x04 clears the enable bits where the data has ones. Zero bits leave the enable bits unchanged. Offset 0x08 reads the enable bits, and a write there has no effect.
- R3: Offset 0x0C reads the pending bits. Writing to 0x10 clears each pending bit whose data bit is 1 and leaves the others unchanged.
- R4: When a line's bit in the trigger-kind word (0x14) is 1, the line is level-triggered. Its bit in the level-polarity word (0x1C) then picks the active level: 1 for high, 0 for low. While the line is at its active level, its pending bit is set.
- R5: When a line's bit in the trigger-kind word is 0, the line is edge-triggered. Its bit in the edge-polarity word (0x18) then picks the edge: 1 for rising, 0 for falling. The opposite edge sets nothing.
- R6: A pending bit stays set after its line goes inactive, until software clears it. If a clear and a trigger for the same line arrive in the same cycle, the bit stays set.
- R7: `cpu_irq` is high exactly when some line is both pending and enabled. A pending line that is not enabled does not raise it.
- R8: `nmi_irq` is high exactly when bit 0 of the word at 0x24 is 1 and line 0 is pending, whatever the enable bits are.
- R9: Bits at or above `NUM_LINES` in the configuration and status words read as zero, even after ones are written there. Bits above bit 0 of the word at 0x24 also read as zero.
- R10: A change on an external line first shows in its pending bit on the third rising clock edge after the change, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| ext_line | input | NUM_LINES | Asynchronous external interrupt lines |
| cpu_irq | output | 1 | Maskable interrupt request |
| nmi_irq | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the block with `NUM_LINES` = 8 and `ADDR_W` = 8. This leaves 24 unbuilt upper bits, enough to show that writing all ones reads back as 0xFF and that the line count can be found this way. Eight lines give room to run each of the four trigger kinds on its own line at the same time, so a trigger on one line can also be shown not to disturb the others. Line 0 is kept for the non-maskable path, so its gating can be checked separately from the enable bits.

// File: rtl/ext_irq_pkg.sv
// Package: ext_irq_pkg
// Holds the register offsets and the register-select decode shared by the
// register file and the checker. It assumes byte addressing on a 32-bit
// data port.
package ext_irq_pkg;

    localparam logic [7:0] OFS_MASK_SET  = 8'h00;
    localparam logic [7:0] OFS_MASK_CLR  = 8'h04;
    localparam logic [7:0] OFS_MASK_RD   = 8'h08;
    localparam logic [7:0] OFS_PEND_RD   = 8'h0C;
    localparam logic [7:0] OFS_PEND_CLR  = 8'h10;
    localparam logic [7:0] OFS_TRIG_KIND = 8'h14;
    localparam logic [7:0] OFS_EDGE_POL  = 8'h18;
    localparam logic [7:0] OFS_LEVEL_POL = 8'h1C;
    localparam logic [7:0] OFS_NMI_CTL   = 8'h24;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MASK_SET,
        SEL_MASK_CLR,
        SEL_MASK_RD,
        SEL_PEND_RD,
        SEL_PEND_CLR,
        SEL_TRIG_KIND,
        SEL_EDGE_POL,
        SEL_LEVEL_POL,
        SEL_NMI_CTL
    } reg_sel_e;

    // Map a byte offset to the register it selects.
    function automatic reg_sel_e decode_sel(input logic [7:0] ofs);
        case (ofs)
            OFS_MASK_SET:  return SEL_MASK_SET;
            OFS_MASK_CLR:  return SEL_MASK_CLR;
            OFS_MASK_RD:   return SEL_MASK_RD;
            OFS_PEND_RD:   return SEL_PEND_RD;
            OFS_PEND_CLR:  return SEL_PEND_CLR;
            OFS_TRIG_KIND: return SEL_TRIG_KIND;
            OFS_EDGE_POL:  return SEL_EDGE_POL;
            OFS_LEVEL_POL: return SEL_LEVEL_POL;
            OFS_NMI_CTL:   return SEL_NMI_CTL;
            default:       return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
// Module: ext_irq_sync
// Brings each asynchronous external line into the clock domain through two
// flops. It assumes each line is a quasi-static level that needs no glitch
// filtering. Output lags the input by two rising edges.
module ext_irq_sync #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_LINES-1:0] line_sync
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic meta_q;
        logic stable_q;

        // Two-stage capture of one line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= line_in[g];
                stable_q <= meta_q;
            end
        end

        assign line_sync[g] = stable_q;
    end

endmodule

// File: rtl/ext_irq_detect.sv
// Module: ext_irq_detect
// Turns the synchronized lines into a per-line trigger pulse or level,
// using the trigger kind and polarity bits. It assumes the configuration
// bits are already in the clock domain. The trigger output is
// combinational from the synchronized sample and one stored past sample.
module ext_irq_detect #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_sync,
    input  logic [NUM_LINES-1:0] kind_level,
    input  logic [NUM_LINES-1:0] edge_rise,
    input  logic [NUM_LINES-1:0] level_high,
    output logic [NUM_LINES-1:0] line_evt
);

    logic [NUM_LINES-1:0] prev_q;

    // Keep the previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= line_sync;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_evt
        logic rise_seen;
        logic fall_seen;
        logic lvl_hit;

        // Select the trigger condition configured for this line.
        always_comb begin
            rise_seen   = line_sync[g] & ~prev_q[g];
            fall_seen   = ~line_sync[g] & prev_q[g];
            lvl_hit     = (line_sync[g] == level_high[g]);
            line_evt[g] = kind_level[g] ? lvl_hit
                        : (edge_rise[g] ? rise_seen : fall_seen);
        end
    end

endmodule

// File: rtl/ext_irq_regs.sv
// Module: ext_irq_regs
// Register file: enable (mask) bits with set and clear words, sticky
// pending bits, trigger configuration, non-maskable control, and the
// read multiplexer. It assumes one access per cycle. Reads are
// combinational, and unbuilt bits read as zero.
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] line_evt,
    output logic [NUM_LINES-1:0] mask_vec,
    output logic [NUM_LINES-1:0] pend_vec,
    output logic [NUM_LINES-1:0] kind_level,
    output logic [NUM_LINES-1:0] edge_rise,
    output logic [NUM_LINES-1:0] level_high,
    output logic                 nmi_en
);

    reg_sel_e             sel;
    logic [NUM_LINES-1:0] wbits;
    logic [NUM_LINES-1:0] pend_clr;
    logic                 unused_wdata;

    // Decode the access and trim the write data to the built lines.
    always_comb begin
        sel          = decode_sel(8'(bus_addr));
        wbits        = bus_wdata[NUM_LINES-1:0];
        pend_clr     = (bus_we && sel == SEL_PEND_CLR) ? wbits : '0;
        unused_wdata = ^bus_wdata;
    end

    // Configuration and enable registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_vec   <= '0;
            kind_level <= '0;
            edge_rise  <= '0;
            level_high <= '0;
            nmi_en     <= 1'b0;
        end else if (bus_we) begin
            case (sel)
                SEL_MASK_SET:  mask_vec   <= mask_vec | wbits;
                SEL_MASK_CLR:  mask_vec   <= mask_vec & ~wbits;
                SEL_TRIG_KIND: kind_level <= wbits;
                SEL_EDGE_POL:  edge_rise  <= wbits;
                SEL_LEVEL_POL: level_high <= wbits;
                SEL_NMI_CTL:   nmi_en     <= bus_wdata[0];
                default:       ;
            endcase
        end
    end

    // Sticky pending bits; a trigger in the clear cycle keeps the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_vec <= '0;
        else        pend_vec <= (pend_vec & ~pend_clr) | line_evt;
    end

    // Read multiplexer, zero-extended to the data width.
    always_comb begin
        case (sel)
            SEL_MASK_RD:   bus_rdata = 32'(mask_vec);
            SEL_PEND_RD:   bus_rdata = 32'(pend_vec);
            SEL_TRIG_KIND: bus_rdata = 32'(kind_level);
            SEL_EDGE_POL:  bus_rdata = 32'(edge_rise);
            SEL_LEVEL_POL: bus_rdata = 32'(level_high);
            SEL_NMI_CTL:   bus_rdata = {31'd0, nmi_en};
            default:       bus_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/ext_irq_ctrl.sv
// Module: ext_irq_ctrl
// Top of the external interrupt controller: synchronizer, trigger detect,
// register file and request outputs. It assumes 1 <= NUM_LINES <= 32 and
// an ADDR_W wide enough to reach offset 0x24.
module ext_irq_ctrl #(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] ext_line,
    output logic                 cpu_irq,
    output logic                 nmi_irq
);

    logic [NUM_LINES-1:0] line_sync;
    logic [NUM_LINES-1:0] line_evt;
    logic [NUM_LINES-1:0] mask_vec;
    logic [NUM_LINES-1:0] pend_vec;
    logic [NUM_LINES-1:0] kind_level;
    logic [NUM_LINES-1:0] edge_rise;
    logic [NUM_LINES-1:0] level_high;
    logic                 nmi_en;

    ext_irq_sync #(.NUM_LINES(NUM_LINES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (ext_line),
        .line_sync (line_sync)
    );

    ext_irq_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_sync  (line_sync),
        .kind_level (kind_level),
        .edge_rise  (edge_rise),
        .level_high (level_high),
        .line_evt   (line_evt)
    );

    ext_irq_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .line_evt   (line_evt),
        .mask_vec   (mask_vec),
        .pend_vec   (pend_vec),
        .kind_level (kind_level),
        .edge_rise  (edge_rise),
        .level_high (level_high),
        .nmi_en     (nmi_en)
    );

    // Combine enabled pending lines and gate the non-maskable request.
    always_comb begin
        cpu_irq = |(pend_vec & mask_vec);
        nmi_irq = nmi_en & pend_vec[0];
    end

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
// Module: ext_irq_ctrl_chk
// Property checker bound to ext_irq_ctrl. It watches the register port,
// the trigger vector and the stored enable and pending bits.
module ext_irq_ctrl_chk
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [31:0]          bus_wdata,
    input logic [NUM_LINES-1:0] line_evt,
    input logic [NUM_LINES-1:0] mask_vec,
    input logic [NUM_LINES-1:0] pend_vec,
    input logic                 nmi_en,
    input logic                 cpu_irq,
    input logic                 nmi_irq
);

    logic                 wr_set;
    logic                 wr_clr;
    logic                 wr_pclr;
    logic [NUM_LINES-1:0] wb;

    always_comb begin
        wr_set  = bus_we && (8'(bus_addr) == OFS_MASK_SET);
        wr_clr  = bus_we && (8'(bus_addr) == OFS_MASK_CLR);
        wr_pclr = bus_we && (8'(bus_addr) == OFS_PEND_CLR);
        wb      = bus_wdata[NUM_LINES-1:0];
    end

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask_vec & $past(wb)) == $past(wb)));                  // R2

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask_vec & $past(wb)) == '0));                         // R2

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pclr |=> ((pend_vec & $past(wb & ~line_evt)) == '0));            // R3

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pclr |=> ((pend_vec & $past(pend_vec)) == $past(pend_vec)));    // R6

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_evt != '0) |=> ((pend_vec & $past(line_evt)) == $past(line_evt))); // R6

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ((pend_vec & mask_vec) != '0));                         // R7

    AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_irq |-> (nmi_en && pend_vec[0]));                               // R8

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .line_evt  (line_evt),
    .mask_vec  (mask_vec),
    .pend_vec  (pend_vec),
    .nmi_en    (nmi_en),
    .cpu_irq   (cpu_irq),
    .nmi_irq   (nmi_irq)
);

// File: tb/ext_irq_ctrl_tb.sv
// Scoreboard bench: driver tasks queue expected values, a monitor pops and
// compares them 5 ns after each rising edge.
module ext_irq_ctrl_tb;

    localparam int NL = 8;
    localparam int AW = 8;

    localparam logic [7:0] A_SET   = 8'h00;
    localparam logic [7:0] A_CLR   = 8'h04;
    localparam logic [7:0] A_MASK  = 8'h08;
    localparam logic [7:0] A_PEND  = 8'h0C;
    localparam logic [7:0] A_PCLR  = 8'h10;
    localparam logic [7:0] A_KIND  = 8'h14;
    localparam logic [7:0] A_EDGE  = 8'h18;
    localparam logic [7:0] A_LEVEL = 8'h1C;
    localparam logic [7:0] A_NMI   = 8'h24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] ext_line = '0;
    logic          cpu_irq;
    logic          nmi_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int          sel;   // 0 read data, 1 cpu_irq, 2 nmi_irq
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    ext_irq_ctrl #(.NUM_LINES(NL), .ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_line  (ext_line),
        .cpu_irq   (cpu_irq),
        .nmi_irq   (nmi_irq)
    );

    // Monitor: compare queued expectations away from the clock edges.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.sel)
                    0:       act = bus_rdata;
                    1:       act = {31'd0, cpu_irq};
                    default: act = {31'd0, nmi_irq};
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = AW'(a);
        it.sel = 0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic pins(input logic c, input logic n, input string tag);
        item_t it;
        it.sel = 1; it.exp = {31'd0, c}; it.tag = {tag, " cpu_irq"};
        sb.push_back(it);
        it.sel = 2; it.exp = {31'd0, n}; it.tag = {tag, " nmi_irq"};
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Driver sequence.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_MASK, 32'h0, "R1 mask");
        rd(A_PEND, 32'h0, "R1 pending");
        rd(A_KIND, 32'h0, "R1 kind");
        rd(A_EDGE, 32'h0, "R1 edge");
        rd(A_LEVEL, 32'h0, "R1 level");
        rd(A_NMI, 32'h0, "R1 nmi ctl");
        pins(1'b0, 1'b0, "R1");

        // R9 line-count probe; all lines then level-low with inputs low
        wr(A_KIND, 32'hFFFF_FFFF);
        rd(A_KIND, 32'h0000_00FF, "R9 kind readback");
        rd(A_PEND, 32'h0000_00FF, "R4 active-low level / R9 pending width");
        wr(A_KIND, 32'h0);
        wr(A_PCLR, 32'hFFFF_FFFF);
        rd(A_PEND, 32'h0, "R3 clear all");

        // R2 enable set/clear and read-only view
        wr(A_SET, 32'h05);
        rd(A_MASK, 32'h05, "R2 set");
        wr(A_SET, 32'h10);
        rd(A_MASK, 32'h15, "R2 set keeps others");
        wr(A_CLR, 32'h01);
        rd(A_MASK, 32'h14, "R2 clear");
        wr(A_MASK, 32'hFF);
        rd(A_MASK, 32'h14, "R2 read-only view");

        // R5 falling mode ignores rising edge on line 1
        ext_line = 8'h02;
        idle(4);
        rd(A_PEND, 32'h0, "R5 rise ignored in falling mode");

        // R10 latency of a falling edge on line 1
        ext_line = 8'h00;
        rd(A_PEND, 32'h0, "R10 edge 1");
        rd(A_PEND, 32'h0, "R10 edge 2");
        rd(A_PEND, 32'h02, "R10 edge 3");

        // R6 sticky, R7 masking
        idle(3);
        rd(A_PEND, 32'h02, "R6 sticky");
        pins(1'b0, 1'b0, "R7 unmasked pending");
        wr(A_SET, 32'h02);
        pins(1'b1, 1'b0, "R7 masked pending");
        wr(A_PCLR, 32'hFD);
        rd(A_PEND, 32'h02, "R3 zero bits keep");
        wr(A_PCLR, 32'h02);
        rd(A_PEND, 32'h0, "R3 clear one");
        pins(1'b0, 1'b0, "R7 after clear");

        // R5 rising mode on line 2
        wr(A_EDGE, 32'h04);
        ext_line = 8'h04;
        idle(4);
        rd(A_PEND, 32'h04, "R5 rising edge");
        wr(A_PCLR, 32'h04);
        ext_line = 8'h00;
        idle(4);
        rd(A_PEND, 32'h0, "R5 fall ignored in rising mode");

        // R4 level-high on line 3, R6 trigger beats clear
        wr(A_LEVEL, 32'h08);
        wr(A_KIND, 32'h08);
        ext_line = 8'h08;
        idle(4);
        rd(A_PEND, 32'h08, "R4 active-high level");
        wr(A_PCLR, 32'h08);
        rd(A_PEND, 32'h08, "R6 active level wins over clear");
        ext_line = 8'h00;
        idle(4);
        wr(A_PCLR, 32'h08);
        rd(A_PEND, 32'h0, "R4 inactive level clears");

        // R4 level-low on line 4 (input already low)
        wr(A_KIND, 32'h18);
        idle(2);
        rd(A_PEND, 32'h10, "R4 active-low level");
        ext_line = 8'h10;
        idle(4);
        wr(A_PCLR, 32'h10);
        rd(A_PEND, 32'h0, "R4 low level released");

        // R8 non-maskable path on line 0
        ext_line = 8'h11;
        idle(4);
        ext_line = 8'h10;
        idle(4);
        rd(A_PEND, 32'h01, "R8 line 0 pending");
        pins(1'b0, 1'b0, "R8 nmi disabled");
        wr(A_NMI, 32'hFFFF_FFFF);
        rd(A_NMI, 32'h1, "R9 nmi ctl width");
        pins(1'b0, 1'b1, "R8 nmi enabled, line unmasked");
        wr(A_SET, 32'h01);
        pins(1'b1, 1'b1, "R7 line 0 enabled");
        wr(A_CLR, 32'h01);
        wr(A_PCLR, 32'h01);
        pins(1'b0, 1'b0, "R8 after clear");
        wr(A_NMI, 32'h0);
        rd(A_NMI, 32'h0, "R8 nmi ctl off");

        idle(3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule